// File: doc/BRIEF.md
# PLL Reference Handover Sequencer

This controller moves the reference input of the system PLL from the on-chip 16 MHz oscillator to an external crystal oscillator. It does this without ever running the system clock from a PLL whose reference is changing underneath it. It runs on the 16 MHz oscillator clock. Both status inputs, crystal-stable and PLL-locked, pass through two-stage synchronizers before the controller uses them.

After a start pulse, the controller waits until the crystal reports stable. It then moves the system clock onto the internal oscillator and holds there for five oscillator cycles. Next it flips the PLL reference to the crystal and waits for lock. Once lock is seen, it hands the system clock back to the PLL and pulses done.

Either wait is bounded by a programmable limit. If the crystal wait times out, the run aborts and leaves both selects untouched. If the lock wait times out, the system clock stays on the internal oscillator. In both cases the error flag is raised and held. The clock multiplexer and the PLL are outside this block.

Top module: `refclk_handover_seq`

## Requirements
- R1: During and after reset, `sys_src_o` is 1 (system clock from PLL) and `pll_ref_o` is 0 (PLL reference from internal oscillator). `busy_o`, `done_o` and `error_o` are 0.
- R2: A `start_i` high at a clock edge while idle makes `busy_o` high after that edge. `busy_o` falls at the edge that raises `done_o` or `error_o`. A `start_i` that arrives while busy has no effect on the sequence or its timing.
- R3: Status inputs pass through a two-stage synchronizer. A crystal-stable input that rises between edge k and edge k+1 is acted on at edge k+3.
- R4: `sys_src_o` drops to 0 (internal oscillator) only after a synchronized crystal-stable is seen during the crystal wait. `pll_ref_o` is still 0 when this happens.
- R5: `pll_ref_o` rises to 1 (crystal) exactly 5 clock cycles after `sys_src_o` fell. `sys_src_o` stays 0 throughout that gap.
- R6: During the lock wait, the synchronized lock status is ignored while the wait counter is below 4. This skips the stale lock left over from the old reference. At the first edge where lock is seen with the counter at 4 or more, `sys_src_o` returns to 1.
- R7: `done_o` is a one-cycle pulse, raised at the same edge that returns `sys_src_o` to 1.
- R8: If the crystal never reports stable, `error_o` rises `timeout_lim_i`+1 cycles after the start edge. Both `sys_src_o` and `pll_ref_o` keep their values.
- R9: If lock is not seen, `error_o` rises `timeout_lim_i`+1 cycles after `pll_ref_o` rose. `sys_src_o` stays 0 and `pll_ref_o` stays 1.
- R10: `error_o` holds until the next accepted start, which clears it at the accept edge.
- R11: `done_o` and `error_o` are never high together, and `busy_o` is low whenever either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin the handover |
| xtal_ok_i | input | 1 | Crystal oscillator stable status (asynchronous) |
| pll_lock_i | input | 1 | PLL lock status (asynchronous) |
| timeout_lim_i | input | TMO_W (8) | Wait limit in clock cycles for each polling step |
| sys_src_o | output | 1 | System clock select: 0 internal oscillator, 1 PLL |
| pll_ref_o | output | 1 | PLL reference select: 0 internal oscillator, 1 crystal |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful handover |
| error_o | output | 1 | Sticky timeout flag |

## Verification
The checker watches several orderings on every cycle:
- parking needs a crystal-stable seen three edges earlier;
- the reference flips exactly five cycles after the park;
- the system clock returns to the PLL only together with done;
- done lasts one cycle;
- error stays held;
- busy starts only from a start request.

Exact cycle counts are left to the bench's scenarios, which compare them against values computed from the stimulus timing. These are the synchronizer latency, the lock blanking window, both timeout lengths with their boundary where lock arrives on the last allowed cycle, and the final select values after each kind of abort. Starts that arrive while busy are also left to the bench.

// File: rtl/refclk_handover_pkg.sv
package refclk_handover_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_XTAL = 2'd1,
        ST_SETTLE    = 2'd2,
        ST_WAIT_LOCK = 2'd3
    } seq_state_e;

    typedef enum logic {
        SYS_FROM_OSC = 1'b0,
        SYS_FROM_PLL = 1'b1
    } sys_src_e;

    typedef enum logic {
        REF_FROM_OSC  = 1'b0,
        REF_FROM_XTAL = 1'b1
    } pll_ref_e;

    // One-cycle actions decided by the next-state logic
    typedef struct packed {
        logic accept;
        logic park;
        logic swap;
        logic finish;
        logic fail;
        logic clr_cnt;
    } seq_act_t;

    localparam int SYNC_STAGES = 2;

    function automatic logic limit_hit(input logic [15:0] cnt, input logic [15:0] lim);
        return cnt == lim;
    endfunction

endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_i;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/refclk_wait_ctr.sv
module refclk_wait_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/refclk_seq_fsm.sv
module refclk_seq_fsm
    import refclk_handover_pkg::*;
#(
    parameter int W          = 8,
    parameter int SETTLE_CYC = 5,
    parameter int LOCK_BLANK = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         xtal_s_i,
    input  logic         lock_s_i,
    input  logic [W-1:0] lim_i,
    input  logic [W-1:0] cnt_i,
    output logic         clr_cnt_o,
    output logic         sys_src_o,
    output logic         pll_ref_o,
    output logic         busy_o,
    output logic         done_o,
    output logic         error_o
);
    localparam logic [W-1:0] SETTLE_LAST = W'(SETTLE_CYC - 1);
    localparam logic [W-1:0] BLANK_END   = W'(LOCK_BLANK);

    seq_state_e st_q, st_d;
    seq_act_t   act;
    sys_src_e   sys_q;
    pll_ref_e   ref_q;
    logic       done_q, err_q;
    logic       tmo;

    assign tmo = limit_hit(16'(cnt_i), 16'(lim_i));

    always_comb begin
        st_d = st_q;
        act  = '0;
        unique case (st_q)
            ST_IDLE: begin
                act.clr_cnt = 1'b1;
                if (start_i) begin
                    act.accept = 1'b1;
                    st_d       = ST_WAIT_XTAL;
                end
            end
            ST_WAIT_XTAL: begin
                if (xtal_s_i) begin
                    act.park    = 1'b1;
                    act.clr_cnt = 1'b1;
                    st_d        = ST_SETTLE;
                end else if (tmo) begin
                    act.fail = 1'b1;
                    st_d     = ST_IDLE;
                end
            end
            ST_SETTLE: begin
                if (cnt_i == SETTLE_LAST) begin
                    act.swap    = 1'b1;
                    act.clr_cnt = 1'b1;
                    st_d        = ST_WAIT_LOCK;
                end
            end
            ST_WAIT_LOCK: begin
                if (lock_s_i && cnt_i >= BLANK_END) begin
                    act.finish = 1'b1;
                    st_d       = ST_IDLE;
                end else if (tmo) begin
                    act.fail = 1'b1;
                    st_d     = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            sys_q  <= SYS_FROM_PLL;
            ref_q  <= REF_FROM_OSC;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= act.finish;
            if (act.park)   sys_q <= SYS_FROM_OSC;
            if (act.finish) sys_q <= SYS_FROM_PLL;
            if (act.swap)   ref_q <= REF_FROM_XTAL;
            if (act.fail)        err_q <= 1'b1;
            else if (act.accept) err_q <= 1'b0;
        end
    end

    assign clr_cnt_o = act.clr_cnt;
    assign sys_src_o = sys_q;
    assign pll_ref_o = ref_q;
    assign busy_o    = (st_q != ST_IDLE);
    assign done_o    = done_q;
    assign error_o   = err_q;
endmodule

// File: rtl/refclk_handover_seq.sv
module refclk_handover_seq
    import refclk_handover_pkg::*;
#(
    parameter int TMO_W      = 8,
    parameter int SETTLE_CYC = 5,
    parameter int LOCK_BLANK = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             xtal_ok_i,
    input  logic             pll_lock_i,
    input  logic [TMO_W-1:0] timeout_lim_i,
    output logic             sys_src_o,
    output logic             pll_ref_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             error_o
);
    localparam int STAT_W = 2;

    logic [STAT_W-1:0] stat_s;
    logic [TMO_W-1:0]  wait_cnt;
    logic              clr_cnt;

    refclk_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({pll_lock_i, xtal_ok_i}),
        .q_o (stat_s)
    );

    refclk_wait_ctr #(.W(TMO_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_cnt),
        .cnt_o (wait_cnt)
    );

    refclk_seq_fsm #(
        .W(TMO_W), .SETTLE_CYC(SETTLE_CYC), .LOCK_BLANK(LOCK_BLANK)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .xtal_s_i  (stat_s[0]),
        .lock_s_i  (stat_s[1]),
        .lim_i     (timeout_lim_i),
        .cnt_i     (wait_cnt),
        .clr_cnt_o (clr_cnt),
        .sys_src_o (sys_src_o),
        .pll_ref_o (pll_ref_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .error_o   (error_o)
    );
endmodule

// File: rtl/refclk_handover_chk.sv
module refclk_handover_chk #(
    parameter int SETTLE_CYC = 5
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic xtal_ok_i,
    input logic sys_src_o,
    input logic pll_ref_o,
    input logic busy_o,
    input logic done_o,
    input logic error_o
);
    logic [7:0] park_gap;

    always_ff @(posedge clk) begin
        if (rst || sys_src_o) begin
            park_gap <= '0;
        end else if (park_gap != 8'hFF) begin
            park_gap <= park_gap + 8'd1;
        end
    end

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i)); // R2
    AST_PARK_NEEDS_XTAL: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_src_o) |-> ($past(xtal_ok_i, 3) && !pll_ref_o)); // R4
    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_ref_o) |-> (park_gap == 8'(SETTLE_CYC) && !sys_src_o)); // R5
    AST_RESTORE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_src_o) |-> (done_o && pll_ref_o)); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (error_o && !(start_i && !busy_o)) |=> error_o); // R10
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_o && error_o)); // R11
    AST_IDLE_ON_FLAG: assert property (@(posedge clk) disable iff (rst)
        (done_o || $rose(error_o)) |-> !busy_o); // R11
endmodule

bind refclk_handover_seq refclk_handover_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .xtal_ok_i (xtal_ok_i),
    .sys_src_o (sys_src_o),
    .pll_ref_o (pll_ref_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .error_o   (error_o)
);

// File: tb/sim_refclk_handover_seq.sv
`timescale 1ns/1ps
module sim_refclk_handover_seq;
    localparam int TMO_W = 8;
    localparam int KIND_OK = 0, KIND_NO_XTAL = 1, KIND_NO_LOCK = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, xtal = 1'b0, lock = 1'b1;
    logic [TMO_W-1:0] lim = '0;
    logic sys_src, pll_ref, busy, done, error;

    int n_checks = 0;
    int n_errors = 0;
    int cyc_total = 0;

    always #4 clk = ~clk;

    refclk_handover_seq #(.TMO_W(TMO_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .xtal_ok_i(xtal),
        .pll_lock_i(lock), .timeout_lim_i(lim), .sys_src_o(sys_src),
        .pll_ref_o(pll_ref), .busy_o(busy), .done_o(done), .error_o(error)
    );

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cyc_total, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_lock_edge(input int dl);
        return (dl + 3 > 5) ? dl + 3 : 5;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; start = 1'b0; xtal = 1'b0; lock = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(sys_src == 1'b1 && pll_ref == 1'b0, "R1 selects", {sys_src, pll_ref}, 2);
        chk(!busy && !done && !error, "R1 flags", {busy, done, error}, 0);
    endtask

    task automatic run(input int kind, input int tl, input int dx, input int dl, input bit poke);
        int t_park = -1, t_ref = -1, t_end = -1;
        bit ended = 0, saw_done = 0, saw_err = 0;
        do_reset();
        lim = TMO_W'(tl); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        for (int cyc = 1; cyc <= 600 && !ended; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            if (t_park < 0 && sys_src == 1'b0) t_park = cyc;
            if (t_ref < 0 && pll_ref == 1'b1) begin t_ref = cyc; lock = 1'b0; end
            if (done || error) begin
                t_end = cyc; ended = 1; saw_done = done; saw_err = error;
                chk(!busy, "R11 busy low with flag", busy, 0);
                chk(!(done && error), "R11 exclusive", {done, error}, 1);
            end
            if (kind != KIND_NO_XTAL && cyc == dx) xtal = 1'b1;
            if (kind == KIND_OK && t_ref > 0 && cyc == t_ref + dl) lock = 1'b1;
            start = poke && (cyc == 2);
        end
        start = 1'b0;
        if (kind == KIND_OK) begin
            chk(saw_done && !saw_err, "R6 completes", saw_done, 1);
            chk(t_park == dx + 3, "R3 sync latency to park", t_park, dx + 3);
            chk(t_ref - t_park == 5, "R5 settle gap", t_ref - t_park, 5);
            chk(t_end - t_ref == exp_lock_edge(dl), "R6 lock accept edge",
                t_end - t_ref, exp_lock_edge(dl));
            chk(sys_src && pll_ref, "R6 final selects", {sys_src, pll_ref}, 3);
            if (poke) chk(t_end == dx + 3 + 5 + exp_lock_edge(dl), "R2 start while busy ignored",
                          t_end, dx + 3 + 5 + exp_lock_edge(dl));
            @(posedge clk); @(negedge clk);
            chk(!done, "R7 done one cycle", done, 0);
            chk(!busy, "R2 stays idle", busy, 0);
        end else begin
            chk(saw_err && !saw_done, "R8 R9 error raised", saw_err, 1);
            if (kind == KIND_NO_XTAL) begin
                chk(t_end == tl + 1, "R8 xtal timeout length", t_end, tl + 1);
                chk(sys_src && !pll_ref && t_park < 0, "R8 selects unchanged", {sys_src, pll_ref}, 2);
            end else begin
                chk(t_end - t_ref == tl + 1, "R9 lock timeout length", t_end - t_ref, tl + 1);
                chk(!sys_src && pll_ref, "R9 parked on oscillator", {sys_src, pll_ref}, 1);
            end
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(error == 1'b1, "R10 error held", error, 1);
            xtal = 1'b0; start = 1'b1;
            @(posedge clk);
            @(negedge clk); start = 1'b0;
            chk(error == 1'b0 && busy, "R10 error cleared by start", error, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // directed corners
        run(KIND_NO_XTAL, 0, 1, 1, 0);
        run(KIND_NO_LOCK, 3, 1, 1, 0);
        run(KIND_OK, 6, 1, 4, 0);   // lock on the last allowed cycle
        run(KIND_OK, 10, 2, 1, 0);  // blanking dominates
        run(KIND_OK, 10, 8, 3, 1);  // xtal on the last allowed cycle, start poke
        for (int i = 0; i < 40; i++) begin
            int tl, kind;
            kind = int'($urandom_range(2, 0));
            tl   = int'($urandom_range(40, 6));
            run(kind, tl, int'($urandom_range(tl - 2, 1)), int'($urandom_range(tl - 2, 1)),
                bit'($urandom_range(1, 0)));
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule